// File: doc/BRIEF.md
# Card Column Word Packer

This block turns a stream of punched card columns into 20-bit machine words for a card input path. Each column arrives as a 12-bit row vector with a one-cycle valid strobe. A card holds 80 columns, and a start pulse marks the beginning of each card.

Two binary layouts are supported. In paired mode, two consecutive columns each give ten bits, and together they form one word, with the earlier column in the upper half. The two zone rows (11 and 12) are dropped in this mode. In single-column mode, each column becomes its own word, with its twelve bits right-aligned. Every word comes out with its position on the card. A done pulse follows the final column of a card.

Top module: `card_word_packer`

## Requirements
- R1: While reset is asserted, and after it is released, `word_valid`, `card_done`, `word_data` and `word_idx` are all zero until a column is accepted.
- R2: Input bit positions follow the row order 12, 11, 0, 1, …, 9, mapped to bits 11 down to 0. With `mode_full` low, an even column (0, 2, …) is held. The next odd column then produces `word_data = {held[9:0], odd[9:0]}` one cycle after the odd column is strobed.
- R3: With `mode_full` low, input bits 11 and 10 (rows 12 and 11) of either column have no effect on `word_data`.
- R4: With `mode_full` high, every accepted column produces `word_data = {8'b0, col_rows}` one cycle after it is strobed.
- R5: `word_idx` equals the column number divided by two (0..39) in paired mode, and the column number (0..79) in single-column mode.
- R6: `card_done` is high for exactly one cycle, in the same cycle as the output for column 79.
- R7: Columns strobed after column 79 of a card produce no word and no `card_done`.
- R8: `card_start` returns the column count to zero and discards a held half word. A column strobed in the same cycle as `card_start` is dropped.
- R9: Cycles with `col_valid` low produce no word and do not advance the column count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_valid | input | 1 | One column is present this cycle |
| col_rows | input | 12 | Row punches, bit 11 = row 12 … bit 0 = row 9 |
| mode_full | input | 1 | 1: one word per column; 0: two columns per word |
| card_start | input | 1 | New card begins; clears column count |
| word_valid | output | 1 | `word_data` and `word_idx` are valid |
| word_data | output | 20 | Assembled word |
| word_idx | output | 7 | Word position on the card |
| card_done | output | 1 | Pulse alongside the output of column 79 |

## Verification
Every result is registered once, so a word, its index and the done pulse appear exactly one clock after the column that completes them. The bench drives inputs on the falling edge and updates its model when it drives. On the next falling edge it compares all outputs against the prediction for that single column. As a result, the checks fall in the one cycle where each result is due, and an extra or missing cycle of latency is reported as a mismatch.

// File: rtl/card_word_packer.sv
module card_word_packer #(
  parameter int COLS      = 80,
  parameter int ROW_BITS  = 12,
  parameter int HALF_BITS = 10,
  parameter int WORD_BITS = 20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          col_valid,
  input  logic [ROW_BITS-1:0]           col_rows,
  input  logic                          mode_full,
  input  logic                          card_start,
  output logic                          word_valid,
  output logic [WORD_BITS-1:0]          word_data,
  output logic [$clog2(COLS)-1:0]       word_idx,
  output logic                          card_done
);
  localparam int CNT_W = $clog2(COLS + 1);
  localparam int IDX_W = $clog2(COLS);
  localparam int PAD_W = WORD_BITS - ROW_BITS;
  localparam logic [CNT_W-1:0] COL_LIMIT = CNT_W'(COLS);
  localparam logic [CNT_W-1:0] COL_LAST  = CNT_W'(COLS - 1);

  logic [CNT_W-1:0]     col_cnt;
  logic [HALF_BITS-1:0] hi_q;

  wire take   = col_valid && !card_start && (col_cnt < COL_LIMIT);
  wire second = col_cnt[0];
  wire [CNT_W-1:0] pair_no = col_cnt >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_cnt    <= '0;
      hi_q       <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
      word_idx   <= '0;
      card_done  <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      card_done  <= 1'b0;
      if (card_start) begin
        col_cnt <= '0;
        hi_q    <= '0;
      end else if (take) begin
        col_cnt   <= col_cnt + CNT_W'(1);
        card_done <= (col_cnt == COL_LAST);
        if (mode_full) begin
          word_valid <= 1'b1;
          word_data  <= {{PAD_W{1'b0}}, col_rows};
          word_idx   <= col_cnt[IDX_W-1:0];
        end else if (!second) begin
          hi_q <= col_rows[HALF_BITS-1:0];
        end else begin
          word_valid <= 1'b1;
          word_data  <= {hi_q, col_rows[HALF_BITS-1:0]};
          word_idx   <= pair_no[IDX_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/card_word_packer_chk.sv
module card_word_packer_chk #(
  parameter int COLS      = 80,
  parameter int ROW_BITS  = 12,
  parameter int HALF_BITS = 10,
  parameter int WORD_BITS = 20
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    col_valid,
  input logic [ROW_BITS-1:0]     col_rows,
  input logic                    mode_full,
  input logic                    card_start,
  input logic                    word_valid,
  input logic [WORD_BITS-1:0]    word_data,
  input logic [$clog2(COLS)-1:0] word_idx,
  input logic                    card_done
);
  a_r9_word_needs_column: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(col_valid));

  a_r8_start_drops_column: assert property (@(posedge clk) disable iff (!rst_n)
    card_start |=> (!word_valid && !card_done));

  a_r4_full_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && $past(mode_full)) |-> (word_data[WORD_BITS-1:ROW_BITS] == '0));

  a_r5_pair_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !$past(mode_full)) |-> (int'(word_idx) < COLS / 2));

  a_r6_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    card_done |=> !card_done);

  a_r6_done_with_word: assert property (@(posedge clk) disable iff (!rst_n)
    card_done |-> word_valid);
endmodule

bind card_word_packer card_word_packer_chk #(
  .COLS(COLS), .ROW_BITS(ROW_BITS), .HALF_BITS(HALF_BITS), .WORD_BITS(WORD_BITS)
) chk_i (.*);

// File: tb/card_word_packer_tb_top.sv
module card_word_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        col_valid;
  logic [11:0] col_rows;
  logic        mode_full;
  logic        card_start;
  logic        word_valid;
  logic [19:0] word_data;
  logic [6:0]  word_idx;
  logic        card_done;

  card_word_packer dut_i (
    .clk(clk), .rst_n(rst_n), .col_valid(col_valid), .col_rows(col_rows),
    .mode_full(mode_full), .card_start(card_start), .word_valid(word_valid),
    .word_data(word_data), .word_idx(word_idx), .card_done(card_done)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int        m_cnt;
  logic [9:0] m_hi;
  logic       e_valid, e_done;
  logic [19:0] e_data;
  logic [6:0]  e_idx;

  function automatic logic [19:0] pair_word(logic [9:0] hi, logic [11:0] lo);
    return {hi, lo[9:0]};
  endfunction

  function automatic logic [19:0] full_word(logic [11:0] r);
    return {8'h00, r};
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input logic [11:0] r, input bit st, input string tag);
    col_valid  = v;
    col_rows   = r;
    card_start = st;
    e_valid = 1'b0;
    e_done  = 1'b0;
    if (st) begin
      m_cnt = 0;
    end else if (v && m_cnt < 80) begin
      if (mode_full) begin
        e_valid = 1'b1;
        e_data  = full_word(r);
        e_idx   = 7'(m_cnt);
      end else if (m_cnt % 2 == 0) begin
        m_hi = r[9:0];
      end else begin
        e_valid = 1'b1;
        e_data  = pair_word(m_hi, r);
        e_idx   = 7'(m_cnt / 2);
      end
      e_done = (m_cnt == 79);
      m_cnt++;
    end
    @(negedge clk);
    check(tag, "word_valid", 32'(word_valid), 32'(e_valid));
    check("R6", "card_done", 32'(card_done), 32'(e_done));
    if (e_valid) begin
      check(tag, "word_data", 32'(word_data), 32'(e_data));
      check("R5", "word_idx", 32'(word_idx), 32'(e_idx));
    end
  endtask

  task automatic run_card(input bit full, input string tag);
    mode_full = full;
    cyc(1'b0, 12'h000, 1'b1, "R8");
    for (int c = 0; c < 80; c++) begin
      if ($urandom % 5 == 0) cyc(1'b0, 12'($urandom), 1'b0, "R9");
      cyc(1'b1, 12'($urandom), 1'b0, tag);
    end
    for (int k = 0; k < 4; k++) cyc(1'b1, 12'($urandom), 1'b0, "R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    rst_n = 1'b0; col_valid = 1'b0; col_rows = '0; mode_full = 1'b0; card_start = 1'b0;
    m_cnt = 0; m_hi = '0; e_data = '0; e_idx = '0;
    repeat (3) @(negedge clk);
    check("R1", "word_valid in reset", 32'(word_valid), 0);
    check("R1", "card_done in reset", 32'(card_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "word_data after reset", 32'(word_data), 0);
    check("R1", "word_idx after reset", 32'(word_idx), 0);

    // R3: zone rows ignored in paired mode
    mode_full = 1'b0;
    cyc(1'b0, 12'h000, 1'b1, "R8");
    cyc(1'b1, 12'hFFF, 1'b0, "R3");
    cyc(1'b1, 12'hC00, 1'b0, "R3");
    check("R3", "zone rows dropped", 32'(word_data), 32'h FFC00);
    cyc(1'b1, 12'h800, 1'b0, "R3");
    cyc(1'b1, 12'h401, 1'b0, "R3");
    check("R3", "zone rows dropped 2", 32'(word_data), 32'h00001);

    // R8: restart discards held half and drops a concurrent column
    cyc(1'b1, 12'h2AA, 1'b0, "R8");
    cyc(1'b1, 12'h155, 1'b1, "R8");
    cyc(1'b1, 12'h0F0, 1'b0, "R8");
    cyc(1'b1, 12'h00F, 1'b0, "R8");
    check("R8", "first word after restart", 32'(word_data), 32'h3C00F);
    check("R8", "index after restart", 32'(word_idx), 0);

    run_card(1'b0, "R2");
    run_card(1'b1, "R4");
    run_card(1'b0, "R2");

    // R8 in full mode: restart mid-card
    mode_full = 1'b1;
    cyc(1'b0, 12'h000, 1'b1, "R8");
    for (int c = 0; c < 7; c++) cyc(1'b1, 12'($urandom), 1'b0, "R4");
    run_card(1'b1, "R4");

    // R9: idle cycles with garbage rows
    for (int k = 0; k < 5; k++) cyc(1'b0, 12'($urandom), 1'b0, "R9");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule